// File: doc/BRIEF.md
# Mode-Scalable Shift-Add 8-Point DCT

This block computes a one-dimensional, eight-point discrete cosine transform of eight signed samples. Multipliers are not used. An input butterfly forms mirrored sums and differences. Six fixed-angle plane rotators then apply the cosine weights, and each rotator is built only from shifted copies of its operands and adders. The even coefficients each come from one rotation of a nested sum or difference pair. Each odd coefficient is the sum of the outputs of two rotators. The combined value is halved, rounded toward minus infinity, and returned in natural order.

Every rotator weight is a 12-bit fraction, and each set bit of that fraction is one shift-add term. An accuracy selector is sampled together with each input vector. It disables the low-order terms of the rotators that feed the higher-frequency coefficients, which trades accuracy for switching activity. The rotator behind X(0) and X(4) always keeps its full term set. The block is fully pipelined. It takes one vector per clock and returns the transform of that vector a fixed three cycles later. The 2-D transpose and quantisation are handled by the surrounding logic.

Top module: `dctc_core`

## Requirements
- R1: A vector presented with `in_valid` high in a given cycle produces `out_valid` high exactly 3 cycles later, carrying that vector's coefficients. Vectors may arrive on consecutive cycles or with idle gaps between them, and each one produces exactly one output, in arrival order.
- R2: While `rst_n` is low, and after its release until the first result, `out_valid` is 0.
- R3: `out_coefs` holds X(k) at bits [k*12 +: 12], with k from 0 to 7 in natural order, each coefficient a signed 12-bit value. X(k) = c(k)/2 · Σ x(n)·cos((2n+1)kπ/16), where c(0)=1/√2 and c(k)=1 otherwise. Sample n sits at bits [n*10 +: 10] of `in_samples` as a signed 10-bit value. With `in_mode` = 2'b00 every coefficient lies within 2.0 of the exact real-valued result.
- R4: An all-zero input vector yields all-zero coefficients in every mode.
- R5: A vector of eight equal samples c yields X(0) = floor(2896·8c / 8192) in every mode (2896 is the 12-bit fraction of cos(π/4)), and X(1) to X(7) equal to exactly 0.
- R6: X(0) and X(4) do not depend on `in_mode`. The same samples give bit-identical X(0) and X(4) in all four mode codes.
- R7: `in_mode` encoding: 2'b00 keeps the full term set; 2'b01 trims the terms of the higher-frequency rotators; 2'b10 trims further. The code 2'b11 yields results bit-identical to 2'b10. The mode is captured with each vector, so modes may change from one cycle to the next.
- R8: Over one fixed set of input vectors, the total absolute error against the exact transform does not decrease from mode 2'b00 to 2'b01, or from 2'b01 to 2'b10.
- R9: While `out_valid` is 0, `out_coefs` keeps the last value it carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector strobe |
| in_mode | input | 2 | Accuracy selector sampled with the vector |
| in_samples | input | 80 | Eight signed 10-bit samples, sample n at bits [n*10 +: 10] |
| out_valid | output | 1 | Result strobe, three cycles after `in_valid` |
| out_coefs | output | 96 | Eight signed 12-bit coefficients in natural order |

## Verification
A fault in the valid pipeline shows at the ports within three cycles. A result would appear early, late, twice or not at all, and a stall or gap stream would lose alignment between vectors and results. A wrong butterfly, rotator routing or term mask shows on the result of the very vector that passed through it. Constant and zero inputs expose a sign or pairing error exactly, because every coefficient except X(0) must then cancel to zero. A wrongly applied pruning mask is caught by the error bound in full mode, by the mode independence of X(0) and X(4), and by the ordering of the aggregate error across modes.

// File: rtl/dctc_pkg.sv
package dctc_pkg;
  localparam int NPT  = 8;   // points per transform
  localparam int NROT = 6;   // rotators in the datapath
  localparam int FRAC = 12;  // fractional bits of each rotation weight

  // cos(k*pi/16) as 12-bit fractions
  localparam int WT1 = 4017;
  localparam int WT2 = 3784;
  localparam int WT3 = 3406;
  localparam int WT4 = 2896;
  localparam int WT5 = 2276;
  localparam int WT6 = 1567;
  localparam int WT7 = 799;

  typedef enum logic [1:0] {
    ACC_FULL   = 2'b00,
    ACC_TRIM   = 2'b01,
    ACC_COARSE = 2'b10,
    ACC_ALIAS  = 2'b11
  } acc_mode_e;

  typedef int rot_tab_t [NROT];

  // rotator 0: X0/X4, 1: X2/X6, 2-3: X1/X7, 4-5: X3/X5
  localparam rot_tab_t ROT_WA   = '{WT4, WT6, WT7, WT3, WT3, WT7};
  localparam rot_tab_t ROT_WB   = '{WT4, WT2, WT1, WT5, WT5, WT1};
  // lowest weight bit kept in each reduced mode
  localparam rot_tab_t ROT_CUT1 = '{0, 2, 4, 4, 4, 4};
  localparam rot_tab_t ROT_CUT2 = '{0, 5, 7, 7, 7, 7};
endpackage

// File: rtl/dctc_bfly.sv
module dctc_bfly
  import dctc_pkg::*;
#(
  parameter  int W  = 10,
  localparam int DW = W + 1,
  localparam int EW = W + 2
) (
  input  logic [NPT*W-1:0]   smp,
  output logic signed [EW-1:0] ev [4],
  output logic signed [DW-1:0] od [4]
);
  localparam int HALF = NPT / 2;

  logic signed [W-1:0]  x  [NPT];
  logic signed [DW-1:0] sm [HALF];

  always_comb begin
    for (int k = 0; k < NPT; k++) begin
      x[k] = $signed(smp[k*W +: W]);
    end
    for (int k = 0; k < HALF; k++) begin
      sm[k] = DW'(x[k]) + DW'(x[NPT-1-k]);
      od[k] = DW'(x[k]) - DW'(x[NPT-1-k]);
    end
    ev[0] = EW'(sm[0]) + EW'(sm[3]);
    ev[1] = EW'(sm[1]) + EW'(sm[2]);
    ev[2] = EW'(sm[0]) - EW'(sm[3]);
    ev[3] = EW'(sm[1]) - EW'(sm[2]);
  end
endmodule

// File: rtl/dctc_rot.sv
module dctc_rot
  import dctc_pkg::*;
#(
  parameter  int IW         = 12,
  parameter  int CA         = WT4,
  parameter  int CB         = WT4,
  parameter  int CUT_TRIM   = 0,
  parameter  int CUT_COARSE = 0,
  localparam int PW         = IW + FRAC + 2
) (
  input  logic [1:0]           mode,
  input  logic signed [IW-1:0] p,
  input  logic signed [IW-1:0] q,
  output logic signed [PW-1:0] u,
  output logic signed [PW-1:0] v
);
  int lo_bit;

  // one gated shifted copy of the operand per set weight bit at or above lo
  function automatic logic signed [PW-1:0] wsum(input logic signed [IW-1:0] a,
                                                input int w, input int lo);
    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] acc;
    ax  = PW'(a);
    acc = '0;
    for (int b = 0; b < FRAC; b++) begin
      if (w[b] && (b >= lo)) acc = acc + (ax <<< b);
    end
    return acc;
  endfunction

  always_comb begin
    case (mode)
      ACC_FULL: lo_bit = 0;
      ACC_TRIM: lo_bit = CUT_TRIM;
      default:  lo_bit = CUT_COARSE;
    endcase
    u = wsum(p, CA, lo_bit) + wsum(q, CB, lo_bit);
    v = wsum(q, CA, lo_bit) - wsum(p, CB, lo_bit);
  end
endmodule

// File: rtl/dctc_core.sv
module dctc_core
  import dctc_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            in_mode,
  input  logic [NPT*W-1:0]      in_samples,
  output logic                  out_valid,
  output logic [NPT*(W+2)-1:0]  out_coefs
);
  localparam int DW = W + 1;
  localparam int EW = W + 2;
  localparam int RW = EW + FRAC + 2;
  localparam int OW = W + 2;
  localparam int SH = FRAC + 1;

  // stage 0: butterfly
  logic signed [EW-1:0] bf_ev [4];
  logic signed [DW-1:0] bf_od [4];

  dctc_bfly #(.W(W)) bfly_i (
    .smp (in_samples),
    .ev  (bf_ev),
    .od  (bf_od)
  );

  // valid pipeline
  logic [2:0] vld_q, vld_d;

  always_comb vld_d = {vld_q[1:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // stage 1 registers
  logic signed [EW-1:0] s1_ev [4];
  logic signed [DW-1:0] s1_od [4];
  logic [1:0]           s1_mode;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_ev   <= bf_ev;
      s1_od   <= bf_od;
      s1_mode <= in_mode;
    end
  end

  // rotator operand routing
  logic signed [EW-1:0] rp [NROT];
  logic signed [EW-1:0] rq [NROT];
  logic signed [EW-1:0] dx [4];

  always_comb begin
    for (int k = 0; k < 4; k++) dx[k] = EW'(s1_od[k]);
    rp[0] = s1_ev[1]; rq[0] = s1_ev[0];
    rp[1] = s1_ev[3]; rq[1] = s1_ev[2];
    rp[2] = dx[3];    rq[2] = dx[0];
    rp[3] = dx[1];    rq[3] = dx[2];
    rp[4] = dx[3];    rq[4] = dx[0];
    rp[5] = dx[1];    rq[5] = dx[2];
  end

  logic signed [RW-1:0] ru [NROT];
  logic signed [RW-1:0] rv [NROT];

  for (genvar g = 0; g < NROT; g++) begin : g_rot
    dctc_rot #(
      .IW         (EW),
      .CA         (ROT_WA[g]),
      .CB         (ROT_WB[g]),
      .CUT_TRIM   (ROT_CUT1[g]),
      .CUT_COARSE (ROT_CUT2[g])
    ) rot_i (
      .mode (s1_mode),
      .p    (rp[g]),
      .q    (rq[g]),
      .u    (ru[g]),
      .v    (rv[g])
    );
  end

  // stage 2 registers
  logic signed [RW-1:0] s2_u [NROT];
  logic signed [RW-1:0] s2_v [NROT];

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      s2_u <= ru;
      s2_v <= rv;
    end
  end

  // stage 3: combine odd pairs, halve, floor
  logic signed [OW-1:0]   cf [NPT];
  logic [NPT*OW-1:0]      coef_d;

  always_comb begin
    cf[0] = OW'(s2_u[0] >>> SH);
    cf[4] = OW'(s2_v[0] >>> SH);
    cf[2] = OW'(s2_u[1] >>> SH);
    cf[6] = OW'(s2_v[1] >>> SH);
    cf[1] = OW'(((RW+1)'(s2_u[2]) + (RW+1)'(s2_u[3])) >>> SH);
    cf[7] = OW'(((RW+1)'(s2_v[2]) + (RW+1)'(s2_v[3])) >>> SH);
    cf[3] = OW'(((RW+1)'(s2_v[4]) - (RW+1)'(s2_u[5])) >>> SH);
    cf[5] = OW'(((RW+1)'(s2_u[4]) + (RW+1)'(s2_v[5])) >>> SH);
    for (int k = 0; k < NPT; k++) coef_d[k*OW +: OW] = cf[k];
  end

  always_ff @(posedge clk) begin
    if (vld_q[1]) out_coefs <= coef_d;
  end

  assign out_valid = vld_q[2];
endmodule

// File: rtl/dctc_chk.sv
module dctc_chk
  import dctc_pkg::*;
#(
  parameter  int W  = 10,
  localparam int OW = W + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [NPT*W-1:0]   in_samples,
  input logic               out_valid,
  input logic [NPT*OW-1:0]  out_coefs
);
  logic [1:0] age;
  logic       seen;
  logic [2:0] zp, dp;
  logic       zin, din;

  always_comb begin
    zin = (in_samples == '0);
    din = 1'b1;
    for (int k = 1; k < NPT; k++) begin
      if (in_samples[k*W +: W] != in_samples[W-1:0]) din = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= '0;
      seen <= 1'b0;
      zp   <= '0;
      dp   <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      seen <= seen | out_valid;
      zp   <= {zp[1:0], in_valid & zin};
      dp   <= {dp[1:0], in_valid & din};
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3))) else $error("latency"); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !out_valid) |-> $stable(out_coefs)) else $error("hold"); // R9

  AST_ZERO_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zp[2]) |-> (out_coefs == '0)) else $error("zero"); // R4

  AST_FLAT_ONLY_DC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dp[2]) |-> (out_coefs[NPT*OW-1:OW] == '0)) else $error("flat"); // R5
endmodule

bind dctc_core dctc_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_samples (in_samples),
  .out_valid  (out_valid),
  .out_coefs  (out_coefs)
);

// File: tb/dctc_core_tb_top.sv
module dctc_core_tb_top;
  import dctc_pkg::*;

  localparam int  W    = 10;
  localparam int  OW   = W + 2;
  localparam int  NR   = 300;
  localparam int  MAXV = 16 + 3 * NR;
  localparam real PI   = 3.14159265358979;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [1:0]           in_mode = 2'b00;
  logic [NPT*W-1:0]     in_samples = '0;
  logic                 out_valid;
  logic [NPT*OW-1:0]    out_coefs;

  always #5 clk = ~clk;

  dctc_core #(.W(W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_samples (in_samples),
    .out_valid  (out_valid),
    .out_coefs  (out_coefs)
  );

  int sx   [MAXV][NPT];
  int smd  [MAXV];
  int sgap [MAXV];
  int tin  [MAXV];
  int res  [MAXV][NPT];
  int tout [MAXV];
  int base [NR][NPT];
  int nv = 0, nout = 0, ncyc = 0, n_chk = 0, n_err = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && nout < MAXV) begin
      for (int k = 0; k < NPT; k++) res[nout][k] = $signed(out_coefs[k*OW +: OW]);
      tout[nout] = ncyc;
      nout++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_r(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
    end
  endtask

  task automatic push(input int v[NPT], input int m, input int g);
    for (int k = 0; k < NPT; k++) sx[nv][k] = v[k];
    smd[nv]  = m;
    sgap[nv] = g;
    nv++;
  endtask

  function automatic int fdiv(input int a, input int b);
    int qt;
    qt = a / b;
    if ((a % b != 0) && (a < 0)) qt = qt - 1;
    return qt;
  endfunction

  function automatic real dct_ref(input int i, input int k);
    real acc;
    acc = 0.0;
    for (int n = 0; n < NPT; n++)
      acc = acc + real'(sx[i][n]) * $cos(real'((2*n+1)*k) * PI / 16.0);
    if (k == 0) acc = acc / $sqrt(2.0);
    return acc / 2.0;
  endfunction

  function automatic real rabs(input real a);
    return (a < 0.0) ? -a : a;
  endfunction

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", nout, nv);
    summary();
    $finish;
  end

  initial begin
    int v[NPT];
    int fixv[NPT];
    int snap;
    real esum[3];
    real emax, e;

    // ---- stimulus list ----
    for (int k = 0; k < NPT; k++) v[k] = 0;
    push(v, 0, 0);                                   // R4 zero
    for (int k = 0; k < NPT; k++) v[k] = 100;  push(v, 0, 0);  // R5
    for (int k = 0; k < NPT; k++) v[k] = -100; push(v, 1, 1);  // R5
    for (int k = 0; k < NPT; k++) v[k] = 511;  push(v, 2, 0);  // R5
    for (int k = 0; k < NPT; k++) v[k] = -512; push(v, 3, 0);  // R5
    fixv = '{37, -200, 455, -512, 12, 300, -77, 199};
    for (int m = 0; m < 4; m++) push(fixv, m, 0);              // R6, R7

    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NPT; k++) base[r][k] = int'($urandom_range(0, 1023)) - 512;
    for (int k = 0; k < NPT; k++) begin
      base[0][k] = (k % 2 == 0) ? 511 : -512;
      base[1][k] = (k % 2 == 0) ? -512 : 511;
      base[2][k] = k * 128 - 512;
      base[3][k] = (k == 0) ? -512 : 511;
    end
    for (int r = 0; r < NR; r++)
      for (int m = 0; m < 3; m++) begin                        // modes interleaved, R7
        for (int k = 0; k < NPT; k++) v[k] = base[r][k];
        push(v, m, ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 2)) : 0);
      end

    // ---- reset ----
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R2", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R2", "valid after reset", int'(out_valid), 0);

    // ---- drive ----
    for (int i = 0; i < nv; i++) begin
      for (int g = 0; g < sgap[i]; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_mode  = smd[i][1:0];
      for (int k = 0; k < NPT; k++) in_samples[k*W +: W] = sx[i][k][W-1:0];
      tin[i] = ncyc;
    end
    @(negedge clk);
    in_valid   = 1'b0;
    in_samples = '0;
    repeat (6) @(negedge clk);

    // ---- R9 hold ----
    for (int c = 0; c < 5; c++) begin
      for (int k = 0; k < NPT; k++) begin
        snap = $signed(out_coefs[k*OW +: OW]);
        chk(snap == res[nv-1][k], "R9", "hold while idle", snap, res[nv-1][k]);
      end
      @(negedge clk);
    end

    // ---- R1 count and latency ----
    chk(nout == nv, "R1", "result count", nout, nv);
    for (int i = 0; i < nv && i < nout; i++)
      chk(tout[i] - tin[i] == 3, "R1", "latency", tout[i] - tin[i], 3);

    // ---- R4 zero vector ----
    for (int k = 0; k < NPT; k++) chk(res[0][k] == 0, "R4", "zero input", res[0][k], 0);

    // ---- R5 flat vectors ----
    for (int i = 1; i <= 4; i++) begin
      chk(res[i][0] == fdiv(2896 * 8 * sx[i][0], 8192), "R5", "flat X0",
          res[i][0], fdiv(2896 * 8 * sx[i][0], 8192));
      for (int k = 1; k < NPT; k++) chk(res[i][k] == 0, "R5", "flat AC", res[i][k], 0);
    end

    // ---- R6 X0/X4 mode independent, R7 alias code ----
    for (int i = 6; i <= 8; i++) begin
      chk(res[i][0] == res[5][0], "R6", "X0 across modes", res[i][0], res[5][0]);
      chk(res[i][4] == res[5][4], "R6", "X4 across modes", res[i][4], res[5][4]);
    end
    for (int k = 0; k < NPT; k++)
      chk(res[8][k] == res[7][k], "R7", "code 11 vs 10", res[8][k], res[7][k]);

    // ---- R3 accuracy, R8 error ordering ----
    for (int m = 0; m < 3; m++) esum[m] = 0.0;
    for (int i = 9; i < nv && i < nout; i++) begin
      emax = 0.0;
      for (int k = 0; k < NPT; k++) begin
        e = rabs(real'(res[i][k]) - dct_ref(i, k));
        esum[smd[i]] = esum[smd[i]] + e;
        if (e > emax) emax = e;
      end
      if (smd[i] == 0) chk_r(emax <= 2.0, "R3", "full-mode max error", emax, 2.0);
    end
    chk_r(esum[0] <= esum[1], "R8", "error full vs trim", esum[0], esum[1]);
    chk_r(esum[1] <= esum[2], "R8", "error trim vs coarse", esum[1], esum[2]);

    summary();
    $finish;
  end
endmodule